// File: doc/BRIEF.md
# Operand Addressing-Mode Decoder

This block sorts a 16-bit instruction word into one of three formats: a one-operand operation, a conditional branch, or a two-operand operation. For each operand it reads the mode field and the register number and works out how the operand is reached. The possible answers are: a register, a register plus an offset, a pointer, a pointer with post-increment, relative to the program counter, an immediate word, an absolute address, or a built-in constant. Registers 3 and 2 are special, because in some modes they produce the constants 0, 1, 2, 4, 8 and all-ones without using an extension word.

The block holds no memory and no arithmetic. An instruction word is taken on a cycle where `in_valid` is high. One clock later the decode appears on registered outputs. Those outputs give the format and opcode, the kind of each operand, any constant value, how many extension words follow and which operand owns the first one, the post-increment step, the byte-register clearing flag, the branch condition and byte displacement, and an estimate of how many cycles the instruction takes. A fetch unit uses the extension count and order to collect the following words. A sequencer uses the cycle estimate to plan its slots.

Top module: `opnd_mode_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are set to zero on that edge, including `out_valid`.
- R2: A word presented with `in_valid` high is decoded on the next clock edge, and `out_valid` is high for exactly the cycles that follow an accepted word. `out_format` is 1 for bits 15:13 = 001 (branch). It is 2 for bits 15:12 of 4 or more (two-operand, opcode = bits 15:12). It is 0 for bits 15:10 = 000100 (one-operand, opcode = bits 9:7).
- R3: Any other word is illegal. This includes a one-operand opcode of 7. An illegal word gives `out_format` 3, `out_illegal` 1, `ext_count` 0 and `cycle_est` 0.
- R4: For a general register, source mode (bits 5:4) 00/01/10/11 gives a `src_kind` of 0 register, 1 indexed, 2 indirect or 3 post-increment. The source register is bits 11:8 for two-operand words and bits 3:0 for one-operand words.
- R5: With register 0, source mode 01 gives kind 4 (PC-relative) and mode 11 gives kind 5 (immediate). Each uses one extension word.
- R6: With register 2, source mode 01 gives kind 6 (absolute), which uses one extension word. Mode 10 gives kind 7 with `src_const` 4, and mode 11 gives kind 7 with `src_const` 8. Neither constant uses an extension word.
- R7: With register 3, every source mode gives kind 7 with no extension word. The constant is 0, 1, 2 or 0xFFFF for modes 00, 01, 10 and 11.
- R8: The destination mode bit (bit 7) of a two-operand word gives `dst_kind` 0 when clear. When set, it gives kind 4 for register 0, kind 6 for register 2 and kind 1 otherwise, and it uses one extension word. One-operand, branch and illegal words report `dst_kind` 0.
- R9: `ext_count` is the total number of extension words. `ext_first_dst` is 1 only when the destination owns an extension word and the source does not. When both own one, the source word comes first.
- R10: `src_step` is 2 for an immediate source, and 2 for post-increment on register 0 or 1. For post-increment on any other register it is 1 when byte (bit 6 = 1) and 2 when word. It is 0 for every other kind.
- R11: `out_byte` copies bit 6 for one- and two-operand words. `out_clr_upper` is 1 for a byte operation whose result goes to a register.
- R12: A branch gives `jump_cond` = bits 12:10 and `jump_disp` = 2 × the sign-extended bits 9:0, as a 16-bit two's-complement value.
- R13: `cycle_est` is 2 for a branch. For a two-operand word it is 1, plus 1 per source extension word, plus 1 for a memory source (kinds 1, 2, 3, 4, 6), plus 3 for a memory destination. For a one-operand word it is 1, plus 1 per extension word, plus 2 for a memory operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decode below belongs to the word accepted last cycle |
| out_format | output | 2 | 0 one-operand, 1 branch, 2 two-operand, 3 illegal |
| out_illegal | output | 1 | Encoding matches no format |
| out_opcode | output | 4 | Operation code of the format |
| out_byte | output | 1 | Byte-sized operation |
| out_clr_upper | output | 1 | Byte result to a register clears its upper byte |
| src_kind | output | 3 | Source (or single) operand kind |
| src_const | output | 16 | Generated constant when `src_kind` is 7 |
| src_step | output | 2 | Post-increment step in bytes |
| dst_kind | output | 3 | Destination operand kind |
| ext_count | output | 2 | Extension words following the instruction |
| ext_first_dst | output | 1 | First extension word belongs to the destination |
| jump_cond | output | 3 | Branch condition code |
| jump_disp | output | 16 | Branch displacement in bytes |
| cycle_est | output | 3 | Estimated execution cycles |

## Verification
Two features can apply to the same word. The first case is when both operands claim an extension word. The source index and the destination index then have to be counted together and put in order. The bench provokes this with words that set indexed mode in both fields, in byte and in word form, and checks for a count of two with the first word going to the source. The second case is a generated constant in the same word as an indexed destination, which must report a single extension word that belongs to the destination. Words that use a general register, register 0 and register 2 as the destination are also checked for the kind, count and cycle estimate they report.

// File: rtl/opdec_pkg.sv
// Shared types for the operand addressing-mode decoder.
// Assumes a 16-bit instruction word and 16 architectural registers.
package opdec_pkg;

    localparam int WORD_W = 16;
    localparam int REG_W  = 4;

    typedef enum logic [2:0] {
        K_REG       = 3'd0,
        K_INDEXED   = 3'd1,
        K_INDIRECT  = 3'd2,
        K_AUTOINC   = 3'd3,
        K_SYMBOLIC  = 3'd4,
        K_IMMEDIATE = 3'd5,
        K_ABSOLUTE  = 3'd6,
        K_CONST     = 3'd7
    } opnd_kind_e;

    typedef enum logic [1:0] {
        F_SINGLE  = 2'd0,
        F_JUMP    = 2'd1,
        F_DOUBLE  = 2'd2,
        F_ILLEGAL = 2'd3
    } insn_fmt_e;

    typedef struct packed {
        opnd_kind_e         kind;
        logic               has_ext;
        logic               is_mem;
        logic [WORD_W-1:0]  cval;
        logic [1:0]         step;
    } opnd_info_t;

    localparam opnd_info_t OPND_NONE = '{kind: K_REG, has_ext: 1'b0, is_mem: 1'b0,
                                         cval: '0, step: 2'd0};

endpackage

// File: rtl/opdec_format.sv
// Format classifier: sorts an instruction word into one-operand, branch,
// two-operand or illegal. Purely combinational; assumes the word is stable.
module opdec_format
    import opdec_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] word,
    output insn_fmt_e    fmt
);

    localparam logic [2:0] JUMP_TAG   = 3'b001;
    localparam logic [5:0] SINGLE_TAG = 6'b000100;
    localparam logic [2:0] SINGLE_BAD = 3'b111;

    // Priority decode of the top bits into a format code.
    always_comb begin
        if (word[W-1 -: 3] == JUMP_TAG)
            fmt = F_JUMP;
        else if (word[W-1 -: 4] >= 4'd4)
            fmt = F_DOUBLE;
        else if (word[W-1 -: 6] == SINGLE_TAG && word[9:7] != SINGLE_BAD)
            fmt = F_SINGLE;
        else
            fmt = F_ILLEGAL;
    end

endmodule

// File: rtl/opdec_operand.sv
// One operand decoder. IS_DST selects the destination variant, which sees only
// a one-bit mode. Registers 0, 2 and 3 get special decodes. Combinational.
module opdec_operand
    import opdec_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int RW     = REG_W,
    parameter bit IS_DST = 1'b0
) (
    input  logic [1:0]    mode,
    input  logic [RW-1:0] rnum,
    input  logic          byte_op,
    output opnd_info_t    info
);

    localparam logic [RW-1:0] R_PC = RW'(0);
    localparam logic [RW-1:0] R_SP = RW'(1);
    localparam logic [RW-1:0] R_SR = RW'(2);
    localparam logic [RW-1:0] R_CG = RW'(3);

    opnd_kind_e kind;
    logic [W-1:0] cval;

    generate
        if (IS_DST) begin : g_dst
            // Destination: direct when the mode bit is clear, otherwise an indexed form.
            always_comb begin
                cval = '0;
                if (!mode[0])            kind = K_REG;
                else if (rnum == R_PC)   kind = K_SYMBOLIC;
                else if (rnum == R_SR)   kind = K_ABSOLUTE;
                else                     kind = K_INDEXED;
            end
        end else begin : g_src
            // Source: four modes, with constant generation on registers 2 and 3.
            always_comb begin
                cval = '0;
                kind = K_REG;
                unique case (mode)
                    2'b00: begin
                        if (rnum == R_CG) kind = K_CONST;
                    end
                    2'b01: begin
                        if (rnum == R_PC)      kind = K_SYMBOLIC;
                        else if (rnum == R_SR) kind = K_ABSOLUTE;
                        else if (rnum == R_CG) begin kind = K_CONST; cval = W'(1); end
                        else                   kind = K_INDEXED;
                    end
                    2'b10: begin
                        if (rnum == R_SR)      begin kind = K_CONST; cval = W'(4); end
                        else if (rnum == R_CG) begin kind = K_CONST; cval = W'(2); end
                        else                   kind = K_INDIRECT;
                    end
                    default: begin
                        if (rnum == R_PC)      kind = K_IMMEDIATE;
                        else if (rnum == R_SR) begin kind = K_CONST; cval = W'(8); end
                        else if (rnum == R_CG) begin kind = K_CONST; cval = '1; end
                        else                   kind = K_AUTOINC;
                    end
                endcase
            end
        end
    endgenerate

    // Attributes that follow from the kind: extension word, memory access, step.
    always_comb begin
        info.kind    = kind;
        info.cval    = cval;
        info.has_ext = (kind == K_INDEXED) || (kind == K_SYMBOLIC) ||
                       (kind == K_ABSOLUTE) || (kind == K_IMMEDIATE);
        info.is_mem  = (kind == K_INDEXED) || (kind == K_INDIRECT) ||
                       (kind == K_AUTOINC) || (kind == K_SYMBOLIC) ||
                       (kind == K_ABSOLUTE);
        if (kind == K_IMMEDIATE)
            info.step = 2'd2;
        else if (kind == K_AUTOINC)
            info.step = (rnum == R_PC || rnum == R_SP || !byte_op) ? 2'd2 : 2'd1;
        else
            info.step = 2'd0;
    end

endmodule

// File: rtl/opdec_cost.sv
// Extension-word accounting and cycle estimate. Assumes the operand
// records are already zeroed for formats that lack them. Combinational.
module opdec_cost
    import opdec_pkg::*;
#(
    parameter int CYC_W = 3
) (
    input  insn_fmt_e        fmt,
    input  opnd_info_t       src,
    input  opnd_info_t       dst,
    output logic [1:0]       ext_count,
    output logic             ext_first_dst,
    output logic [CYC_W-1:0] cycles
);

    localparam logic [CYC_W-1:0] JUMP_CYC = CYC_W'(2);
    localparam logic [CYC_W-1:0] DST_MEM  = CYC_W'(3);
    localparam logic [CYC_W-1:0] ONE_MEM  = CYC_W'(2);

    // Count extension words and work out who owns the first of them.
    always_comb begin
        ext_count     = 2'd0;
        ext_first_dst = 1'b0;
        if (fmt == F_SINGLE) begin
            ext_count = {1'b0, src.has_ext};
        end else if (fmt == F_DOUBLE) begin
            ext_count     = {1'b0, src.has_ext} + {1'b0, dst.has_ext};
            ext_first_dst = dst.has_ext && !src.has_ext;
        end
    end

    // One cycle per word fetched or stored.
    always_comb begin
        unique case (fmt)
            F_JUMP:   cycles = JUMP_CYC;
            F_SINGLE: cycles = CYC_W'(1) + CYC_W'(src.has_ext)
                               + (src.is_mem ? ONE_MEM : '0);
            F_DOUBLE: cycles = CYC_W'(1) + CYC_W'(src.has_ext) + CYC_W'(src.is_mem)
                               + (dst.is_mem ? DST_MEM : '0);
            default:  cycles = '0;
        endcase
    end

endmodule

// File: rtl/opnd_mode_decoder.sv
// Top of the operand addressing-mode decoder. Splits the word into fields by
// format, runs the source and destination decoders and the cost logic, and
// registers the result one cycle after in_valid. Synchronous active-low reset.
module opnd_mode_decoder
    import opdec_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int RW    = REG_W,
    parameter int CYC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_word,
    output logic             out_valid,
    output logic [1:0]       out_format,
    output logic             out_illegal,
    output logic [3:0]       out_opcode,
    output logic             out_byte,
    output logic             out_clr_upper,
    output logic [2:0]       src_kind,
    output logic [W-1:0]     src_const,
    output logic [1:0]       src_step,
    output logic [2:0]       dst_kind,
    output logic [1:0]       ext_count,
    output logic             ext_first_dst,
    output logic [2:0]       jump_cond,
    output logic [W-1:0]     jump_disp,
    output logic [CYC_W-1:0] cycle_est
);

    localparam int OFS_W = 10;

    insn_fmt_e        fmt;
    opnd_info_t       src_raw, dst_raw, src_i, dst_i;
    logic [RW-1:0]    src_reg;
    logic [1:0]       n_ext;
    logic             n_first_dst;
    logic [CYC_W-1:0] n_cyc;
    logic [3:0]       n_opc;
    logic             n_byte;
    logic             n_clr;
    logic [W-1:0]     n_disp;

    opdec_format #(.W(W)) u_fmt (
        .word (in_word),
        .fmt  (fmt)
    );

    // Pick the source register field for the format in use.
    always_comb begin
        src_reg = (fmt == F_DOUBLE) ? in_word[11:8] : in_word[RW-1:0];
    end

    opdec_operand #(.W(W), .RW(RW), .IS_DST(1'b0)) u_src (
        .mode    (in_word[5:4]),
        .rnum    (src_reg),
        .byte_op (in_word[6]),
        .info    (src_raw)
    );

    opdec_operand #(.W(W), .RW(RW), .IS_DST(1'b1)) u_dst (
        .mode    ({1'b0, in_word[7]}),
        .rnum    (in_word[RW-1:0]),
        .byte_op (in_word[6]),
        .info    (dst_raw)
    );

    // Mask operand records that the current format does not carry.
    always_comb begin
        src_i = (fmt == F_SINGLE || fmt == F_DOUBLE) ? src_raw : OPND_NONE;
        dst_i = (fmt == F_DOUBLE) ? dst_raw : OPND_NONE;
    end

    opdec_cost #(.CYC_W(CYC_W)) u_cost (
        .fmt           (fmt),
        .src           (src_i),
        .dst           (dst_i),
        .ext_count     (n_ext),
        .ext_first_dst (n_first_dst),
        .cycles        (n_cyc)
    );

    // Opcode, size and register-clear flag by format.
    always_comb begin
        n_opc  = 4'd0;
        n_byte = 1'b0;
        n_clr  = 1'b0;
        if (fmt == F_DOUBLE) begin
            n_opc  = in_word[15:12];
            n_byte = in_word[6];
            n_clr  = in_word[6] && (dst_i.kind == K_REG);
        end else if (fmt == F_SINGLE) begin
            n_opc  = {1'b0, in_word[9:7]};
            n_byte = in_word[6];
            n_clr  = in_word[6] && (src_i.kind == K_REG);
        end
    end

    // Branch displacement in bytes: sign-extended offset times two.
    always_comb begin
        n_disp = '0;
        if (fmt == F_JUMP)
            n_disp = {{(W-OFS_W-1){in_word[OFS_W-1]}}, in_word[OFS_W-1:0], 1'b0};
    end

    // Output register stage; loads only on an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_format    <= 2'd0;
            out_illegal   <= 1'b0;
            out_opcode    <= 4'd0;
            out_byte      <= 1'b0;
            out_clr_upper <= 1'b0;
            src_kind      <= 3'd0;
            src_const     <= '0;
            src_step      <= 2'd0;
            dst_kind      <= 3'd0;
            ext_count     <= 2'd0;
            ext_first_dst <= 1'b0;
            jump_cond     <= 3'd0;
            jump_disp     <= '0;
            cycle_est     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_format    <= fmt;
                out_illegal   <= (fmt == F_ILLEGAL);
                out_opcode    <= n_opc;
                out_byte      <= n_byte;
                out_clr_upper <= n_clr;
                src_kind      <= src_i.kind;
                src_const     <= src_i.cval;
                src_step      <= src_i.step;
                dst_kind      <= dst_i.kind;
                ext_count     <= n_ext;
                ext_first_dst <= n_first_dst;
                jump_cond     <= (fmt == F_JUMP) ? in_word[12:10] : 3'd0;
                jump_disp     <= n_disp;
                cycle_est     <= n_cyc;
            end
        end
    end

    AST_PIPE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (ext_count == 2'd0 && cycle_est == '0)); // R3
    AST_CONST_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_format == F_SINGLE && src_kind == K_CONST) |-> (ext_count == 2'd0)); // R7
    AST_EXT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ext_count == 2'd2) |-> !ext_first_dst); // R9
    AST_STEP_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && src_kind != K_AUTOINC && src_kind != K_IMMEDIATE) |-> (src_step == 2'd0)); // R10
    AST_JUMP_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_format == F_JUMP) |-> (cycle_est == CYC_W'(2) && ext_count == 2'd0)); // R13

endmodule

// File: tb/opnd_mode_decoder_tb.sv
`timescale 1ns/1ps
module opnd_mode_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_valid, out_illegal, out_byte, out_clr_upper, ext_first_dst;
    logic [1:0]  out_format, src_step, ext_count;
    logic [3:0]  out_opcode;
    logic [2:0]  src_kind, dst_kind, jump_cond, cycle_est;
    logic [15:0] src_const, jump_disp;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    opnd_mode_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_format(out_format), .out_illegal(out_illegal),
        .out_opcode(out_opcode), .out_byte(out_byte), .out_clr_upper(out_clr_upper),
        .src_kind(src_kind), .src_const(src_const), .src_step(src_step),
        .dst_kind(dst_kind), .ext_count(ext_count), .ext_first_dst(ext_first_dst),
        .jump_cond(jump_cond), .jump_disp(jump_disp), .cycle_est(cycle_est)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Present one word, then return at the negedge where its decode is visible.
    task automatic issue(input logic [15:0] w);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic chk_main(input string req, input int fmt, input int sk, input int dk,
                            input int ext, input int cyc);
        chk(req, "valid", out_valid, 1);
        chk(req, "format", out_format, fmt);
        chk(req, "src_kind", src_kind, sk);
        chk(req, "dst_kind", dst_kind, dk);
        chk(req, "ext_count", ext_count, ext);
        chk(req, "cycle_est", cycle_est, cyc);
    endtask

    task automatic t_reset();
        chk("R1", "valid after reset", out_valid, 0);
        chk("R1", "format after reset", out_format, 0);
        chk("R1", "cycles after reset", cycle_est, 0);
        chk("R1", "disp after reset", jump_disp, 0);
    endtask

    task automatic t_general_modes();
        issue(16'h4506); chk_main("R4", 2, 0, 0, 0, 1); chk("R2", "opcode", out_opcode, 4);
        issue(16'h4516); chk_main("R4", 2, 1, 0, 1, 3);
        issue(16'h4526); chk_main("R4", 2, 2, 0, 0, 2); chk("R10", "step", src_step, 0);
        issue(16'h4536); chk_main("R4", 2, 3, 0, 0, 2); chk("R10", "step word", src_step, 2);
        issue(16'h1115); chk_main("R13", 0, 1, 0, 1, 4); chk("R2", "opcode", out_opcode, 2);
    endtask

    task automatic t_pc_sr_modes();
        issue(16'h4016); chk_main("R5", 2, 4, 0, 1, 3);
        issue(16'h4036); chk_main("R5", 2, 5, 0, 1, 2); chk("R10", "imm step", src_step, 2);
        issue(16'h4216); chk_main("R6", 2, 6, 0, 1, 3);
        issue(16'h4226); chk_main("R6", 2, 7, 0, 0, 1); chk("R6", "const4", src_const, 4);
        issue(16'h4236); chk_main("R6", 2, 7, 0, 0, 1); chk("R6", "const8", src_const, 8);
        chk("R10", "const step", src_step, 0);
    endtask

    task automatic t_cg_modes();
        issue(16'h4306); chk_main("R7", 2, 7, 0, 0, 1); chk("R7", "c0", src_const, 0);
        issue(16'h4316); chk_main("R7", 2, 7, 0, 0, 1); chk("R7", "c1", src_const, 1);
        issue(16'h4326); chk_main("R7", 2, 7, 0, 0, 1); chk("R7", "c2", src_const, 2);
        issue(16'h4336); chk_main("R7", 2, 7, 0, 0, 1); chk("R7", "cm1", src_const, 16'hFFFF);
        issue(16'h1232); chk_main("R7", 0, 7, 0, 0, 1); chk("R7", "single c8", src_const, 8);
        // constant source with an indexed destination: one word, owned by dst
        issue(16'h4396); chk_main("R9", 2, 7, 1, 1, 4); chk("R9", "first dst", ext_first_dst, 1);
    endtask

    task automatic t_dst_and_order();
        issue(16'h4586); chk_main("R8", 2, 0, 1, 1, 4); chk("R9", "first dst", ext_first_dst, 1);
        issue(16'h4580); chk_main("R8", 2, 0, 4, 1, 4);
        issue(16'h4582); chk_main("R8", 2, 0, 6, 1, 4);
        issue(16'h5596); chk_main("R9", 2, 1, 1, 2, 6); chk("R9", "src first", ext_first_dst, 0);
        chk("R2", "opcode", out_opcode, 5);
        issue(16'h45D6); chk_main("R13", 2, 1, 1, 2, 6); chk("R9", "src first b", ext_first_dst, 0);
        chk("R11", "byte", out_byte, 1); chk("R11", "no clr mem", out_clr_upper, 0);
    endtask

    task automatic t_step_byte();
        issue(16'h4576); chk("R10", "byte step", src_step, 1); chk("R11", "byte", out_byte, 1);
        chk("R11", "clr reg dst", out_clr_upper, 1);
        issue(16'h4176); chk("R10", "sp step", src_step, 2);
        issue(16'h4076); chk("R5", "pc byte imm", src_kind, 5); chk("R10", "pc step", src_step, 2);
        issue(16'h1145); chk("R11", "single clr", out_clr_upper, 1); chk("R11", "single byte", out_byte, 1);
        issue(16'h1105); chk_main("R2", 0, 0, 0, 0, 1); chk("R11", "word no clr", out_clr_upper, 0);
    endtask

    task automatic t_illegal();
        logic [15:0] bad [3];
        bad[0] = 16'h0000; bad[1] = 16'h1400; bad[2] = 16'h1380;
        foreach (bad[i]) begin
            issue(bad[i]);
            chk("R3", "format", out_format, 3);
            chk("R3", "illegal", out_illegal, 1);
            chk("R3", "ext", ext_count, 0);
            chk("R3", "cycles", cycle_est, 0);
        end
        issue(16'h1300); chk("R3", "reti legal", out_illegal, 0);
    endtask

    task automatic t_jump();
        issue(16'h3FFF); chk_main("R12", 1, 0, 0, 0, 2);
        chk("R12", "cond", jump_cond, 7); chk("R12", "disp -2", jump_disp, 16'hFFFE);
        issue(16'h2005); chk("R12", "cond0", jump_cond, 0); chk("R12", "disp 10", jump_disp, 10);
        issue(16'h2200); chk("R12", "disp min", jump_disp, 16'hFC00);
        issue(16'h29FF); chk("R12", "cond2", jump_cond, 2); chk("R12", "disp max", jump_disp, 16'h03FE);
        chk("R13", "jump cycles", cycle_est, 2);
    endtask

    task automatic t_back_to_back();
        @(negedge clk); in_word = 16'h4036; in_valid = 1'b1;
        @(negedge clk); in_word = 16'h3FFF;
        chk("R2", "b2b first kind", src_kind, 5);
        @(negedge clk); in_valid = 1'b0;
        chk("R2", "b2b second fmt", out_format, 1);
        chk("R2", "b2b second valid", out_valid, 1);
        @(negedge clk);
        chk("R2", "idle valid low", out_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_general_modes();
        t_pc_sr_modes();
        t_cg_modes();
        t_dst_and_order();
        t_step_byte();
        t_illegal();
        t_jump();
        t_back_to_back();
        @(negedge clk); rst_n = 1'b0;
        issue(16'h5596);
        t_reset();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule